// File: doc/BRIEF.md
# Dual-Organization Static RAM Core with Sampled Controls

This block is a synthesizable model of a bit-wide static RAM driven by active-low select, write and output-enable strobes. It has a separate data-in pin and a tri-state data-out pin. A free-running sampling clock watches the strobes so that the asynchronous behaviour can be built from ordinary flip-flops. Every input first passes a two-flop synchronizer. All later decisions (mode decode, write commit, output drive) use the synchronized copies.

An organization input chooses how the array is seen. When it is low the array is one bit wide, and every address picks a single cell. When it is high the same storage is seen as 4-bit words at a quarter of the depth. The data buses are 4 lanes wide, and lane 0 is the pin used in bit-wide operation. The tri-state output is modelled as a data bus plus a per-lane drive enable. A standby flag shows when the part is deselected. A one-cycle error pulse flags an address that moves while a write is in progress.

Top module: `dsram_dualorg`

## Requirements
- R1: While select (`cs_n_i`) is high, no lane is driven (`dout_en_o` = 0), no cell is written and `standby_o` is 1.
- R2: While select and write (`we_n_i`) are both low, no lane is driven.
- R3: A write stores the address and data held in the last sampled cycle of the select/write overlap. It commits when the overlap ends, and it does not matter whether write or select rises first.
- R4: With select low, write high and output-enable (`oe_n_i`) low, the output drives the stored contents of the addressed location.
- R5: With select low, write high and output-enable high, no lane is driven and `standby_o` is 0.
- R6: If write goes low before or together with select, the output is never driven during that access.
- R7: With `org_x4_i` low, address bits [ADDR_W-1:ADDR_W-2] pick lane 0..3 and the low bits pick the word. A write stores `din_i[0]`, and a read drives only lane 0 (`dout_en_o` = 4'b0001).
- R8: With `org_x4_i` high, the top two address bits are ignored. A write stores all four `din_i` lanes into the word, and a read drives all four lanes (`dout_en_o` = 4'b1111). Lane n of a word is the cell that bit-wide mode reaches with top address bits equal to n.
- R9: If the sampled address changes between two consecutive sampled cycles that both lie inside the write overlap, `addr_err_o` pulses high for one cycle.
- R10: Any lane whose enable is low outputs 0.
- R11: Reset is synchronous and active low. After reset the sampled controls are idle, no lane is driven and `standby_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Cell address |
| cs_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| org_x4_i | input | 1 | 1 = 4-bit word organization, 0 = bit-wide |
| din_i | input | 4 | Write data; lane 0 is the bit-wide pin |
| dout_o | output | 4 | Read data; lane 0 is the bit-wide pin |
| dout_en_o | output | 4 | Per-lane output drive enable (0 = high impedance) |
| standby_o | output | 1 | High while deselected |
| addr_err_o | output | 1 | One-cycle pulse on an address change during a write |

## Verification
Each port change is taken in on one rising edge and reaches the decode on the next. So the drive enables, read data and standby flag show the new input state just after the second edge. A write commits on the third edge after the port change that ends the overlap. The error pulse also shows after the third edge following the address move. The bench models this with a history of the inputs it applied at each edge, indexed by those depths. One nanosecond after every edge it compares all four outputs against that model and a shadow array.

// File: rtl/dsram_pkg.sv
// Package: shared types and decode for the dual-organization SRAM core.
// Assumes all strobes are active low and already synchronized.
package dsram_pkg;

    localparam int LANES  = 4;
    localparam int LSEL_W = 2;

    typedef enum logic [1:0] {
        ACC_DESEL = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_QUIET = 2'd3
    } acc_mode_t;

    // Decode the access mode from synchronized strobes; select dominates.
    function automatic acc_mode_t decode_mode(input logic cs_n, input logic we_n,
                                              input logic oe_n);
        if (cs_n)       return ACC_DESEL;
        else if (!we_n) return ACC_WRITE;
        else if (!oe_n) return ACC_READ;
        else            return ACC_QUIET;
    endfunction

endpackage

// File: rtl/dsram_sync.sv
// Module: two-flop synchronizer of W bits into the sampling clock domain.
// Assumes the inputs may change at any time; RST_VAL sets the idle value.
module dsram_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage capture with synchronous reset to the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dsram_ctrl.sv
// Module: access-mode decode, write-commit timing and address-stability check.
// Assumes synchronized inputs. It holds one cycle of history, so a commit is
// issued in the first sampled cycle after the overlap and carries the address,
// data and organization of the overlap's last sampled cycle.
module dsram_ctrl
    import dsram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_cs_n,
    input  logic              s_we_n,
    input  logic              s_oe_n,
    input  logic              s_org,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [LANES-1:0]  s_din,
    output acc_mode_t         mode_o,
    output logic              commit_o,
    output logic [ADDR_W-1:0] cm_addr_o,
    output logic [LANES-1:0]  cm_din_o,
    output logic              cm_org_o,
    output logic              err_o
);
    logic              prev_wr_q;
    logic [ADDR_W-1:0] prev_addr_q;
    logic [LANES-1:0]  prev_din_q;
    logic              prev_org_q;
    logic              cur_wr;

    // Current mode from the synchronized strobes.
    always_comb begin
        mode_o = decode_mode(s_cs_n, s_we_n, s_oe_n);
        cur_wr = (mode_o == ACC_WRITE);
    end

    // Remember the previous sampled cycle for edge and stability detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_wr_q   <= 1'b0;
            prev_addr_q <= '0;
            prev_din_q  <= '0;
            prev_org_q  <= 1'b0;
        end else begin
            prev_wr_q   <= cur_wr;
            prev_addr_q <= s_addr;
            prev_din_q  <= s_din;
            prev_org_q  <= s_org;
        end
    end

    // Commit at the end of the overlap, whichever strobe released it.
    always_comb begin
        commit_o  = prev_wr_q && !cur_wr;
        cm_addr_o = prev_addr_q;
        cm_din_o  = prev_din_q;
        cm_org_o  = prev_org_q;
    end

    // Flag an address that moved between two sampled cycles of one overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= prev_wr_q && cur_wr && (s_addr != prev_addr_q);
    end

    p_commit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    p_commit_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(mode_o) == ACC_WRITE) && (mode_o != ACC_WRITE));

    p_err_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(mode_o) == ACC_WRITE));
endmodule

// File: rtl/dsram_lane.sv
// Module: one lane of storage, single write port, asynchronous read.
// Assumes the caller gates the write enable; contents are not reset.
module dsram_lane #(
    parameter int WORD_W = 10,
    localparam int WORDS = 1 << WORD_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [WORD_W-1:0] waddr,
    input  logic              wdata,
    input  logic [WORD_W-1:0] raddr,
    output logic              rdata
);
    logic mem [WORDS];

    // Store one bit when the lane is selected for a commit.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read path is combinational from the sampled address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/dsram_dualorg.sv
// Module: top of the dual-organization SRAM core.
// Synchronizes all inputs, decodes the access, steers commits to one lane
// (bit-wide) or all lanes (4-bit word) and drives the modelled tri-state
// output. Assumes the address and data are stable during a write overlap.
module dsram_dualorg
    import dsram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic              org_x4_i,
    input  logic [3:0]        din_i,
    output logic [3:0]        dout_o,
    output logic [3:0]        dout_en_o,
    output logic              standby_o,
    output logic              addr_err_o
);
    localparam int WORD_W = ADDR_W - LSEL_W;

    logic [3:0]          s_ctl;
    logic [ADDR_W-1:0]   s_addr;
    logic [LANES-1:0]    s_din;
    logic                s_cs_n, s_we_n, s_oe_n, s_org;
    acc_mode_t           mode;
    logic                commit, cm_org;
    logic [ADDR_W-1:0]   cm_addr;
    logic [LANES-1:0]    cm_din;
    logic [LANES-1:0]    lane_we, lane_wd, rd_bits;
    logic [LSEL_W-1:0]   rd_lane, wr_lane;

    dsram_sync #(.W(4), .RST_VAL(4'b0111)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({org_x4_i, oe_n_i, we_n_i, cs_n_i}), .q(s_ctl)
    );

    dsram_sync #(.W(ADDR_W + LANES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n),
        .d({addr_i, din_i}), .q({s_addr, s_din})
    );

    // Unpack the synchronized strobes.
    always_comb begin
        s_cs_n = s_ctl[0];
        s_we_n = s_ctl[1];
        s_oe_n = s_ctl[2];
        s_org  = s_ctl[3];
    end

    dsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .s_cs_n(s_cs_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n), .s_org(s_org),
        .s_addr(s_addr), .s_din(s_din),
        .mode_o(mode), .commit_o(commit), .cm_addr_o(cm_addr),
        .cm_din_o(cm_din), .cm_org_o(cm_org), .err_o(addr_err_o)
    );

    assign wr_lane = cm_addr[ADDR_W-1 -: LSEL_W];
    assign rd_lane = s_addr[ADDR_W-1 -: LSEL_W];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Steer the commit: every lane in word mode, one lane in bit mode.
        always_comb begin
            lane_we[l] = commit && (cm_org || (wr_lane == LSEL_W'(l)));
            lane_wd[l] = cm_org ? cm_din[l] : cm_din[0];
        end

        dsram_lane #(.WORD_W(WORD_W)) u_lane (
            .clk(clk), .we(lane_we[l]),
            .waddr(cm_addr[WORD_W-1:0]), .wdata(lane_wd[l]),
            .raddr(s_addr[WORD_W-1:0]), .rdata(rd_bits[l])
        );
    end

    // Output stage: drive only in read mode, undriven lanes forced to zero.
    always_comb begin
        dout_o    = '0;
        dout_en_o = '0;
        if (mode == ACC_READ) begin
            if (s_org) begin
                dout_o    = rd_bits;
                dout_en_o = 4'b1111;
            end else begin
                dout_o[0]    = rd_bits[rd_lane];
                dout_en_o[0] = 1'b1;
            end
        end
        standby_o = (mode == ACC_DESEL);
    end

    p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> (dout_en_o == 4'b0000));

    p_desel_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(standby_o) |-> (lane_we == '0));

    p_write_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_cs_n && !s_we_n) |-> (dout_en_o == 4'b0000));

    p_read_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_cs_n && s_we_n && !s_oe_n) |-> (dout_en_o != 4'b0000));

    p_quiet_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_cs_n && s_we_n && s_oe_n) |-> (dout_en_o == 4'b0000) && !standby_o);

    p_x1_lane0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout_en_o != 4'b0000) && !s_org) |-> (dout_en_o == 4'b0001));

    p_x1_onehot_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_org |-> $onehot0(lane_we));

    p_x4_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout_en_o != 4'b0000) && s_org) |-> (dout_en_o == 4'b1111));

    p_undriven_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_o & ~dout_en_o) == 4'b0000);
endmodule

// File: tb/dsram_dualorg_test.sv
// Bench: drives the ports on falling edges and keeps a history of the inputs
// seen at each rising edge. One nanosecond after every rising edge it
// compares all outputs with a behavioural model and a shadow array.
module dsram_dualorg_test;
    localparam int AW    = 12;
    localparam int WORDS = 1 << (AW - 2);
    localparam int CELLS = 1 << AW;

    typedef struct {
        bit          cs_n, we_n, oe_n, org;
        logic [AW-1:0] addr;
        logic [3:0]  din;
    } smp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [AW-1:0] addr_i = '0;
    logic          cs_n_i = 1, we_n_i = 1, oe_n_i = 1, org_x4_i = 0;
    logic [3:0]    din_i = '0;
    logic [3:0]    dout_o, dout_en_o;
    logic          standby_o, addr_err_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  shadow [CELLS];
    bit  known  [CELLS];
    smp_t hist [$];
    string scen = "reset";

    always #2 clk = ~clk;

    dsram_dualorg #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs_n_i(cs_n_i),
        .we_n_i(we_n_i), .oe_n_i(oe_n_i), .org_x4_i(org_x4_i), .din_i(din_i),
        .dout_o(dout_o), .dout_en_o(dout_en_o), .standby_o(standby_o),
        .addr_err_o(addr_err_o)
    );

    function automatic smp_t idle_smp();
        smp_t s;
        s.cs_n = 1; s.we_n = 1; s.oe_n = 1; s.org = 0; s.addr = '0; s.din = '0;
        return s;
    endfunction

    function automatic bit is_wr(smp_t s);
        return !s.cs_n && !s.we_n;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, scen, act, exp);
        end
    endtask

    // Model one rising edge, then compare every output.
    task automatic model_and_check(bit in_rst);
        smp_t c, p, s;
        int n;
        logic [3:0] e_en, e_dat, e_mask;
        bit e_err;
        string tag;
        hist.push_back(in_rst ? idle_smp() : smp_t'{cs_n_i, we_n_i, oe_n_i, org_x4_i, addr_i, din_i});
        if (in_rst) hist[hist.size()-2] = idle_smp();
        n = hist.size();
        c = hist[n-3];
        p = hist[n-4];
        s = hist[n-2];
        e_err = 0;
        if (!in_rst) begin
            // R3: commit the last overlap sample once the overlap has ended.
            if (is_wr(p) && !is_wr(c)) begin
                for (int l = 0; l < 4; l++) begin
                    if (p.org) begin
                        shadow[l*WORDS + int'(p.addr[AW-3:0])] = p.din[l];
                        known[l*WORDS + int'(p.addr[AW-3:0])]  = 1;
                    end else if (l == int'(p.addr[AW-1:AW-2])) begin
                        shadow[p.addr] = p.din[0];
                        known[p.addr]  = 1;
                    end
                end
            end
            e_err = is_wr(p) && is_wr(c) && (p.addr != c.addr);
        end
        e_en = 4'b0000; e_dat = 4'b0000; e_mask = 4'b1111;
        if (s.cs_n)       tag = "R1";
        else if (!s.we_n) tag = "R2";
        else if (s.oe_n)  tag = "R5";
        else begin
            tag = s.org ? "R8" : "R7";
            if (s.org) begin
                e_en = 4'b1111;
                for (int l = 0; l < 4; l++) begin
                    e_dat[l]  = shadow[l*WORDS + int'(s.addr[AW-3:0])];
                    e_mask[l] = known[l*WORDS + int'(s.addr[AW-3:0])];
                end
            end else begin
                e_en = 4'b0001;
                e_dat[0]  = shadow[s.addr];
                e_mask[0] = known[s.addr];
            end
        end
        if (in_rst) tag = "R11";
        if (hist.size() > 8) void'(hist.pop_front());
        chk(dout_en_o == e_en, tag, dout_en_o, e_en);
        // R4 and R10: stored data on driven lanes, zero on the rest.
        chk((dout_o & e_mask) == (e_dat & e_mask), (e_en == 0) ? "R10" : "R4",
            dout_o, e_dat);
        chk(standby_o == s.cs_n, in_rst ? "R11" : (s.cs_n ? "R1" : "R5"),
            standby_o, s.cs_n);
        chk(addr_err_o == e_err, "R9", addr_err_o, e_err);
    endtask

    task automatic step(logic [AW-1:0] a, bit cs, bit we, bit oe, bit org,
                        logic [3:0] d);
        @(negedge clk);
        addr_i = a; cs_n_i = cs; we_n_i = we; oe_n_i = oe; org_x4_i = org;
        din_i = d;
        @(posedge clk);
        #1;
        model_and_check(!rst_n);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(addr_i, 1, 1, 1, org_x4_i, din_i);
    endtask

    // Write ended by the write strobe (we_first=1) or by select.
    task automatic wr(logic [AW-1:0] a, logic [3:0] d, bit org, bit we_first);
        step(a, 0, 1, 1, org, d);
        for (int i = 0; i < 3; i++) step(a, 0, 0, 1, org, d);
        if (we_first) step(a, 0, 1, 1, org, d);
        step(a, 1, 1, 1, org, d);
        idle(2);
    endtask

    task automatic rd(logic [AW-1:0] a, bit org);
        for (int i = 0; i < 3; i++) step(a, 0, 1, 0, org, 4'h0);
        idle(2);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) hist.push_back(idle_smp());
        for (int i = 0; i < CELLS; i++) begin shadow[i] = 0; known[i] = 0; end
        for (int i = 0; i < 4; i++) step('0, 1, 1, 1, 0, 4'h0);
        @(negedge clk); rst_n = 1;
        scen = "R11 after reset";
        idle(3);

        scen = "R7 bit-wide writes across lanes, R3 write strobe ends overlap";
        for (int k = 0; k < 16; k++)
            wr(AW'(k * 263 + 5), {3'b101, 1'(k % 3 == 0)}, 0, 1);
        scen = "R3 select ends overlap";
        wr(AW'(12'hC07), 4'b1110, 0, 0);
        wr(AW'(12'h407), 4'b0001, 0, 0);
        scen = "R4 R7 R10 bit-wide reads";
        for (int k = 0; k < 16; k++) rd(AW'(k * 263 + 5), 0);
        rd(AW'(12'hC07), 0);
        rd(AW'(12'h407), 0);

        scen = "R8 word writes, top bits ignored";
        wr(AW'(12'hF21), 4'b1010, 1, 1);
        wr(AW'(12'h033), 4'b0110, 1, 0);
        wr(AW'(12'h7FF), 4'b1111, 1, 1);
        rd(AW'(12'h321), 1);
        rd(AW'(12'hC33), 1);
        rd(AW'(12'h3FF), 1);
        scen = "R8 word lanes seen bit-wide";
        for (int l = 0; l < 4; l++) rd(AW'(l * WORDS + 12'h321), 0);

        scen = "R5 select low, output enable high";
        for (int i = 0; i < 4; i++) step(AW'(12'h321), 0, 1, 1, 1, 4'h0);
        idle(2);

        scen = "R6 write strobe falls before select";
        step(AW'(12'h0A0), 1, 0, 0, 0, 4'h1);
        for (int i = 0; i < 4; i++) step(AW'(12'h0A0), 0, 0, 0, 0, 4'h1);
        step(AW'(12'h0A0), 1, 0, 0, 0, 4'h1);
        step(AW'(12'h0A0), 1, 1, 1, 0, 4'h1);
        idle(2);
        scen = "R6 strobes fall together";
        for (int i = 0; i < 3; i++) step(AW'(12'h0A1), 0, 0, 0, 0, 4'h0);
        step(AW'(12'h0A1), 1, 1, 0, 0, 4'h0);
        idle(2);
        rd(AW'(12'h0A0), 0);
        rd(AW'(12'h0A1), 0);

        scen = "R9 address moves during overlap";
        step(AW'(12'h100), 0, 1, 1, 0, 4'h1);
        step(AW'(12'h100), 0, 0, 1, 0, 4'h1);
        step(AW'(12'h100), 0, 0, 1, 0, 4'h1);
        step(AW'(12'h101), 0, 0, 1, 0, 4'h0);
        step(AW'(12'h101), 0, 0, 1, 0, 4'h0);
        step(AW'(12'h101), 0, 1, 1, 0, 4'h0);
        idle(3);
        rd(AW'(12'h101), 0);

        scen = "R1 deselected strobes";
        for (int i = 0; i < 4; i++) step(AW'(12'h005), 1, 0, 0, 0, 4'hF);
        idle(2);
        rd(AW'(12'h005), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired [%s] actual=0 expected=1", scen);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule